// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer for a system that is clocked fast but counts time with a slow tick of about 32 kHz. The tick arrives as a one-cycle strobe, `tick_i`. Software controls the block through a 32-bit register bus. Every register write must carry a register-specific key or a fixed code word. A write without it, such as a stray write or a runaway loop, cannot arm, disarm or reconfigure the timer.

Once armed, the counter runs down from a timeout set in coarse units of `TICKS_PER_UNIT` ticks. When it reaches the end it takes one of three actions:

- It raises a system reset pulse.
- It raises a sticky interrupt.
- In two-stage mode, it raises the interrupt first and, if software has not restarted the counter within one further timeout, raises the reset.

The reset pulse can also be copied onto an external pin. The pin can be gated off, and its polarity can be chosen.

Writes are always accepted in the cycle they are presented, so the bus has no back-pressure. Reads are combinational on the address.

Top module: `wdt_keyed`

## Requirements
- R1: Mode register, offset 0x00. A write takes effect only when data[31:24] equals 0x22; any other write there leaves it unchanged. The bit map is:
  - bit0: run enable
  - bit1: external pin polarity (1 = active high)
  - bit2: external pin enable
  - bit3: interrupt enable
  - bit4: auto-start (stored only)
  - bit6: two-stage mode
  - bit8: counter select (stored only)

  A read returns these bits, with the key field and every other bit read as zero.
- R2: Timeout register, offset 0x04. A write takes effect only when data[4:0] equals 0x08, and it takes the timeout in units from data[5 +: LEN_W]. A read returns the units shifted left by 5, with bits [4:0] zero.
- R3: Restart register, offset 0x08. Writing exactly 0x00001971 reloads the counter and clears the interrupt and the two-stage state. Any other value there has no effect.
- R4: The counter expires exactly units×TICKS_PER_UNIT ticks after it is loaded. It is loaded when the run bit goes from 0 to 1 and on every restart. A timeout of 0 units expires on every tick.
- R5: With interrupt enable clear, an expiry starts a reset pulse and reloads the counter.
- R6: With interrupt enable set and two-stage mode clear, an expiry sets the interrupt and never resets. The interrupt stays high until a restart or until the run bit is cleared.
- R7: With interrupt enable and two-stage mode both set, the first expiry sets the interrupt and reloads the counter. A second expiry with no restart in between starts a reset pulse.
- R8: Software reset register, offset 0x14. Writing exactly 0x00001209 starts a reset pulse, whether or not the timer runs. Any other value has no effect.
- R9: A reset pulse keeps `sys_rst_o` high for exactly RST_TICKS ticks.
- R10: `ext_rst_o` carries the reset pulse only while the external pin enable is set, with the level chosen by bit1. Otherwise it rests at the inactive level: low when bit1 is 1, high when bit1 is 0.
- R11: While the run bit is clear the counter holds its reload value and never expires, and the interrupt is low.
- R12: The default LEN_W holds 1984 units, which is 31 s at 512 ticks per unit of a 32768 Hz tick. A write of 1984 units reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per slow-clock tick |
| wr_en_i | input | 1 | Write strobe, accepted in the same cycle |
| addr_i | input | ADDR_W | Byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Early-warning interrupt, level |
| sys_rst_o | output | 1 | System reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin, polarity selectable |

## Verification
The results fall due at different cycles:
- A register write is visible on `rdata_o` from the cycle after its write edge.
- A restart, or setting the run bit, loads the counter two edges after the write, because the reload request is registered once.
- An expiry, or a software-reset write, raises `sys_rst_o` two edges after the deciding tick or write.
- The interrupt follows one edge after the expiring tick.

The bench drives everything on falling edges and leaves three idle clocks after every write and every tick before it samples. Each sample therefore lands after the latest of these latencies, while no further tick can have moved the counter. Expiry times are computed as units×TICKS_PER_UNIT and swept over several timeout values with a small unit size.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam logic [7:0]  OFS_MODE   = 8'h00;
  localparam logic [7:0]  OFS_LEN    = 8'h04;
  localparam logic [7:0]  OFS_KICK   = 8'h08;
  localparam logic [7:0]  OFS_SWRST  = 8'h14;

  localparam logic [7:0]  MODE_KEY   = 8'h22;
  localparam logic [4:0]  LEN_KEY    = 5'h08;
  localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
  localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

  typedef struct packed {
    logic cnt_sel;
    logic dual;
    logic auto_start;
    logic irq_en;
    logic ext_en;
    logic ext_pol;
    logic run;
  } wdt_mode_t;

  function automatic wdt_mode_t mode_from_word(input logic [31:0] w);
    wdt_mode_t m;
    m.run        = w[0];
    m.ext_pol    = w[1];
    m.ext_en     = w[2];
    m.irq_en     = w[3];
    m.auto_start = w[4];
    m.dual       = w[6];
    m.cnt_sel    = w[8];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input wdt_mode_t m);
    logic [31:0] w;
    w    = '0;
    w[0] = m.run;
    w[1] = m.ext_pol;
    w[2] = m.ext_en;
    w[3] = m.irq_en;
    w[4] = m.auto_start;
    w[6] = m.dual;
    w[8] = m.cnt_sel;
    return w;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              dual_o,
  output logic              ext_en_o,
  output logic              ext_pol_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              reload_o,
  output logic              swrst_o
);

  wdt_mode_t        mode_q;
  logic [LEN_W-1:0] len_q;
  logic             reload_q, swrst_q;

  logic hit_mode, hit_len, hit_kick, hit_swrst;
  logic mode_ok, len_ok, kick_ok, swrst_ok;

  always_comb begin
    hit_mode  = wr_en_i && (addr_i == ADDR_W'(OFS_MODE));
    hit_len   = wr_en_i && (addr_i == ADDR_W'(OFS_LEN));
    hit_kick  = wr_en_i && (addr_i == ADDR_W'(OFS_KICK));
    hit_swrst = wr_en_i && (addr_i == ADDR_W'(OFS_SWRST));
    mode_ok   = hit_mode  && (wdata_i[31:24] == MODE_KEY);
    len_ok    = hit_len   && (wdata_i[4:0] == LEN_KEY);
    kick_ok   = hit_kick  && (wdata_i == KICK_CODE);
    swrst_ok  = hit_swrst && (wdata_i == SWRST_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      len_q    <= '0;
      reload_q <= 1'b0;
      swrst_q  <= 1'b0;
    end else begin
      if (mode_ok) mode_q <= mode_from_word(wdata_i);
      if (len_ok)  len_q  <= wdata_i[5 +: LEN_W];
      reload_q <= kick_ok || (mode_ok && wdata_i[0] && !mode_q.run);
      swrst_q  <= swrst_ok;
    end
  end

  always_comb begin
    if (addr_i == ADDR_W'(OFS_MODE))     rdata_o = mode_to_word(mode_q);
    else if (addr_i == ADDR_W'(OFS_LEN)) rdata_o = 32'(len_q) << 5;
    else                                 rdata_o = '0;
  end

  assign run_o     = mode_q.run;
  assign irq_en_o  = mode_q.irq_en;
  assign dual_o    = mode_q.dual;
  assign ext_en_o  = mode_q.ext_en;
  assign ext_pol_o = mode_q.ext_pol;
  assign len_o     = len_q;
  assign reload_o  = reload_q;
  assign swrst_o   = swrst_q;

  // R1
  mode_key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mode && wdata_i[31:24] != MODE_KEY) |=> $stable(mode_q));

  // R2
  len_key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_len && wdata_i[4:0] != LEN_KEY) |=> $stable(len_q));

  // R3
  kick_code_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_kick && wdata_i != KICK_CODE) |=> !reload_o);

  // R8
  swrst_code_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_swrst && wdata_i != SWRST_CODE) |=> !swrst_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int LEN_W          = 11,
  parameter int TICKS_PER_UNIT = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic             dual_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             reload_i,
  output logic             irq_o,
  output logic             expire_rst_o
);

  localparam int CNT_W = LEN_W + $clog2(TICKS_PER_UNIT) + 1;

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             irq_q, stage_q, expire_rst_q;
  logic             expire;

  always_comb begin
    load_val = CNT_W'(len_i) * CNT_W'(TICKS_PER_UNIT);
    expire   = run_i && !reload_i && tick_i && (cnt_q <= CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      irq_q        <= 1'b0;
      stage_q      <= 1'b0;
      expire_rst_q <= 1'b0;
    end else begin
      expire_rst_q <= 1'b0;
      if (!run_i || reload_i) begin
        cnt_q   <= load_val;
        irq_q   <= 1'b0;
        stage_q <= 1'b0;
      end else if (expire) begin
        cnt_q <= load_val;
        if (!irq_en_i) begin
          expire_rst_q <= 1'b1;
        end else if (dual_i && stage_q) begin
          expire_rst_q <= 1'b1;
          stage_q      <= 1'b0;
        end else begin
          irq_q   <= 1'b1;
          stage_q <= dual_i;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign irq_o        = irq_q;
  assign expire_rst_o = expire_rst_q;

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en_i));

  // R7
  rst_from_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_rst_q |-> ($past(!irq_en_i) || $past(dual_i && stage_q)));

  // R11
  idle_never_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !expire_rst_q);

endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  input  logic ext_en_i,
  input  logic ext_pol_i,
  output logic sys_rst_o,
  output logic ext_rst_o
);

  localparam int RW = $clog2(RST_TICKS + 1);

  logic [RW-1:0] rem_q;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rem_q <= '0;
    else if (start_i)                  rem_q <= RW'(RST_TICKS);
    else if (tick_i && rem_q != '0)    rem_q <= rem_q - RW'(1);
  end

  always_comb begin
    active    = (rem_q != '0);
    sys_rst_o = active;
    ext_rst_o = ext_pol_i ? (active && ext_en_i) : !(active && ext_en_i);
  end

  // R9
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> sys_rst_o);

  // R10
  pin_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_o || !ext_en_i) |-> (ext_rst_o == !ext_pol_i));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W         = 8,
  parameter int LEN_W          = 11,
  parameter int TICKS_PER_UNIT = 512,
  parameter int RST_TICKS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o
);

  logic             run, irq_en, dual, ext_en, ext_pol;
  logic [LEN_W-1:0] len;
  logic             reload, swrst, expire_rst;

  wdt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .run_o(run), .irq_en_o(irq_en),
    .dual_o(dual), .ext_en_o(ext_en), .ext_pol_o(ext_pol), .len_o(len),
    .reload_o(reload), .swrst_o(swrst)
  );

  wdt_counter #(.LEN_W(LEN_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .irq_en_i(irq_en), .dual_i(dual), .len_i(len), .reload_i(reload),
    .irq_o(irq_o), .expire_rst_o(expire_rst)
  );

  wdt_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .start_i(expire_rst || swrst), .ext_en_i(ext_en), .ext_pol_i(ext_pol),
    .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
  );

  // R8
  swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> sys_rst_o);

endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

  localparam int TPU  = 4;
  localparam int RSTT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, sys_rst_o, ext_rst_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdt_keyed #(.ADDR_W(8), .LEN_W(11), .TICKS_PER_UNIT(TPU), .RST_TICKS(RSTT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
    settle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
    settle();
  endtask

  function automatic logic [31:0] lenw(input int u);
    return (32'(u) << 5) | 32'h8;
  endfunction

  localparam logic [31:0] M_OFF = 32'h2200_0000;

  task automatic stop_and_clear();
    wr(8'h00, M_OFF);
    ticks(RSTT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(8'h00, d); chk("R1 reset mode", d, 32'h0);
    chk("R6 reset irq", 32'(irq_o), 0);
    chk("R9 reset sys_rst", 32'(sys_rst_o), 0);
    chk("R10 reset pin idle", 32'(ext_rst_o), 1);

    // R1 bad key ignored
    wr(8'h00, 32'h1100_0001); rd(8'h00, d); chk("R1 bad key", d, 32'h0);
    // R1 readback of defined bits only
    wr(8'h00, 32'h2200_01DE); rd(8'h00, d); chk("R1 readback", d, 32'h0000_015E);
    wr(8'h00, M_OFF);

    // R2 length key
    wr(8'h04, lenw(3)); rd(8'h04, d); chk("R2 good key", d, 32'(3) << 5);
    wr(8'h04, (32'(5) << 5) | 32'h7); rd(8'h04, d); chk("R2 bad key", d, 32'(3) << 5);
    // R12 31 s representable
    wr(8'h04, lenw(1984)); rd(8'h04, d); chk("R12 1984 units", d, 32'(1984) << 5);

    // R4/R5 sweep of timeouts, reset on expiry
    for (int u = 1; u <= 4; u++) begin
      wr(8'h04, lenw(u));
      wr(8'h00, 32'h2200_0001);
      ticks(u * TPU - 1);
      chk($sformatf("R4 no expiry before %0d ticks", u * TPU), 32'(sys_rst_o), 0);
      ticks(1);
      chk($sformatf("R5 expiry at %0d ticks", u * TPU), 32'(sys_rst_o), 1);
      stop_and_clear();
      chk("R9 pulse over", 32'(sys_rst_o), 0);
    end

    // R9 pulse length
    wr(8'h04, lenw(4));
    wr(8'h00, 32'h2200_0001);
    ticks(4 * TPU);
    ticks(RSTT - 1);
    chk("R9 pulse still high", 32'(sys_rst_o), 1);
    ticks(1);
    chk("R9 pulse ends", 32'(sys_rst_o), 0);
    wr(8'h00, M_OFF);

    // R3 wrong restart code ignored
    wr(8'h00, 32'h2200_0001);
    ticks(10);
    wr(8'h08, 32'h0000_1970);
    ticks(6);
    chk("R3 wrong code ignored", 32'(sys_rst_o), 1);
    stop_and_clear();
    // R3 correct restart reloads
    wr(8'h00, 32'h2200_0001);
    ticks(10);
    wr(8'h08, 32'h0000_1971);
    ticks(15);
    chk("R3 restart delays expiry", 32'(sys_rst_o), 0);
    ticks(1);
    chk("R3 expiry after restart", 32'(sys_rst_o), 1);
    stop_and_clear();

    // R6 interrupt only
    wr(8'h04, lenw(2));
    wr(8'h00, 32'h2200_0009);
    ticks(7);
    chk("R6 irq not yet", 32'(irq_o), 0);
    ticks(1);
    chk("R6 irq set", 32'(irq_o), 1);
    chk("R6 no reset", 32'(sys_rst_o), 0);
    ticks(8);
    chk("R6 irq sticky", 32'(irq_o), 1);
    chk("R6 never resets", 32'(sys_rst_o), 0);
    wr(8'h08, 32'h0000_1971);
    chk("R6 restart clears irq", 32'(irq_o), 0);
    wr(8'h00, M_OFF);

    // R7 two-stage
    wr(8'h00, 32'h2200_0049);
    ticks(8);
    chk("R7 first stage irq", 32'(irq_o), 1);
    chk("R7 first stage no reset", 32'(sys_rst_o), 0);
    ticks(7);
    chk("R7 second stage pending", 32'(sys_rst_o), 0);
    ticks(1);
    chk("R7 second stage reset", 32'(sys_rst_o), 1);
    stop_and_clear();
    wr(8'h00, 32'h2200_0049);
    ticks(8);
    wr(8'h08, 32'h0000_1971);
    chk("R7 restart clears irq", 32'(irq_o), 0);
    ticks(8);
    chk("R7 restart resets stage", 32'(sys_rst_o), 0);
    chk("R7 irq again", 32'(irq_o), 1);
    wr(8'h00, M_OFF);

    // R11 disable holds counter and clears irq
    wr(8'h00, 32'h2200_0009);
    ticks(8);
    chk("R11 irq before disable", 32'(irq_o), 1);
    wr(8'h00, 32'h2200_0008);
    chk("R11 disable clears irq", 32'(irq_o), 0);
    ticks(20);
    chk("R11 held no irq", 32'(irq_o), 0);
    chk("R11 held no reset", 32'(sys_rst_o), 0);
    wr(8'h00, 32'h2200_0009);
    ticks(7);
    chk("R4 enable reloads", 32'(irq_o), 0);
    ticks(1);
    chk("R4 full period after enable", 32'(irq_o), 1);
    wr(8'h00, M_OFF);

    // R10 external pin
    wr(8'h04, lenw(1));
    wr(8'h00, 32'h2200_0007);
    ticks(TPU);
    chk("R10 active-high pulse", 32'(ext_rst_o), 1);
    wr(8'h00, 32'h2200_0006); ticks(RSTT);
    chk("R10 active-high idle", 32'(ext_rst_o), 0);
    wr(8'h00, 32'h2200_0005);
    ticks(TPU);
    chk("R10 active-low pulse", 32'(ext_rst_o), 0);
    wr(8'h00, 32'h2200_0004); ticks(RSTT);
    chk("R10 active-low idle", 32'(ext_rst_o), 1);
    wr(8'h00, 32'h2200_0003);
    ticks(TPU);
    chk("R10 gated sys_rst", 32'(sys_rst_o), 1);
    chk("R10 gated pin", 32'(ext_rst_o), 0);
    stop_and_clear();

    // R8 software reset
    wr(8'h14, 32'h0000_1208);
    chk("R8 wrong code ignored", 32'(sys_rst_o), 0);
    wr(8'h14, 32'h0000_1209);
    chk("R8 immediate reset", 32'(sys_rst_o), 1);
    ticks(RSTT);
    chk("R9 swrst pulse ends", 32'(sys_rst_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule